// File: doc/BRIEF.md
# Load Queue with Ordered Squash

This block is the load-ordering queue of an out-of-order core. Dispatch writes one load per cycle at the tail. Each entry holds the load's sequence number, its effective address with a valid flag, and a tag that gives the store-queue position current when the load entered. Commit retires entries from the head in program order. A pipeline flush removes every load younger than a given sequence number. It does this by stepping back from the tail, one entry per cycle. The head, the tail and the per-slot valid bits are brought out for a neighbouring ordering checker. A small blocked-load record is also kept, and a flush older than that record clears it.

The ring has one slot more than its capacity. This keeps the full case apart from the empty case. A two-state machine controls the flush. `LQ_IDLE` accepts allocation and takes a flush request through the transition *start* into `LQ_WALK`. In `LQ_WALK`, the transition *step* removes the entry just before the tail and stays in the state. The transition *stop* returns to `LQ_IDLE` when that entry is not younger or the queue is empty. A further flush request in `LQ_WALK` keeps the machine walking and lowers the bound to the older of the two numbers. Sequence numbers are compared as plain unsigned values.

Top module: `load_queue`

## Requirements
- R1: After reset the queue is empty (`occ_o`=0, `vld_o`=0), `busy_o`, `ovf_o` and `blocked_o` are 0, and `free_o` equals the smaller of CAP and SQ_CAP-`sq_cnt_i`.
- R2: An accepted allocation writes the slot at the tail and advances the tail by one, wrapping from CAP to 0. The ring has CAP+1 slots, so it is full at CAP entries. `occ_o` never exceeds CAP.
- R3: A new entry's store tag (TAG_W = store index width + 1) is `sq_tail_i` when `sq_cnt_i` is nonzero. When `sq_cnt_i` is zero it is the all-ones value (15 by default).
- R4: While `commit_i` is high, at most one entry retires per cycle: the head entry, and only if the queue is non-empty and its sequence number is less than or equal to `commit_seq_i`.
- R5: An allocation and a commit in the same cycle both take effect.
- R6: An allocation while full, in `LQ_IDLE` and with no flush request, is dropped. `ovf_o` is then high for exactly the following cycle.
- R7: A flush request moves to `LQ_WALK` with `busy_o` high. Each cycle, the entry before the tail is removed while it is younger than the bound. The machine returns to `LQ_IDLE` once that entry is not younger or the queue is empty. With N younger entries, `busy_o` stays high for N+1 cycles.
- R8: An allocation while `busy_o` is high, or in the same cycle as a flush request, is dropped and does not raise `ovf_o`.
- R9: `free_o` is min(CAP-`occ_o`, SQ_CAP-`sq_cnt_i`), and the store term is taken as 0 if `sq_cnt_i` is at or above SQ_CAP.
- R10: `blk_set_i` records `blk_seq_i` and raises `blocked_o`. A flush request with a sequence number below the recorded one clears `blocked_o` and `blocked_seq_o` to 0. A set in the same cycle wins.
- R11: An address write to a valid slot stores the address and sets that entry's address-valid flag. A new entry starts with the flag clear.
- R12: The popcount of `vld_o` always equals `occ_o`. A commit and a flush step that fall in the same cycle never remove the same slot; the commit takes it and the walk stops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| alloc_i | input | 1 | Allocate a load |
| alloc_seq_i | input | SEQ_W | Sequence number of the new load |
| alloc_rdy_o | output | 1 | Idle and not full |
| sq_tail_i | input | SQ_IDX_W | Current store-queue tail |
| sq_cnt_i | input | SQ_CNT_W | Current store-queue occupancy |
| addr_wr_i | input | 1 | Write an effective address |
| addr_idx_i | input | IDX_W | Slot for the address write |
| addr_val_i | input | ADDR_W | Effective address |
| commit_i | input | 1 | Commit request |
| commit_seq_i | input | SEQ_W | Youngest committed sequence number |
| squash_i | input | 1 | Flush request |
| squash_seq_i | input | SEQ_W | Keep loads at or below this number |
| blk_set_i | input | 1 | Record a blocked load |
| blk_seq_i | input | SEQ_W | Blocked load's sequence number |
| blocked_o | output | 1 | Blocked record present |
| blocked_seq_o | output | SEQ_W | Recorded blocked sequence number |
| busy_o | output | 1 | Flush walk in progress |
| ovf_o | output | 1 | One-cycle overflow pulse |
| free_o | output | CNT_W | Free entries shared with the store queue |
| occ_o | output | CNT_W | Entries held |
| head_o | output | IDX_W | Head slot |
| tail_o | output | IDX_W | Tail slot |
| vld_o | output | DEPTH | Per-slot valid bits |
| head_seq_o | output | SEQ_W | Head entry sequence number |
| head_addr_o | output | ADDR_W | Head entry address |
| head_av_o | output | 1 | Head entry address valid |
| head_tag_o | output | TAG_W | Head entry store tag |

## Verification
Commit can fall in the same cycle as allocation, and it can also fall in the same cycle as a flush request or flush step. The bench drives a commit and an allocation on one edge, then checks that the occupancy is unchanged and the head has advanced. It also drives a commit of the oldest load on the same edge as a flush that removes the rest. It then checks that the walk stops on an empty queue with no valid bit left and that each slot was removed once.

// File: rtl/lq_pkg.sv
package lq_pkg;
    typedef enum logic {
        LQ_IDLE = 1'b0,
        LQ_WALK = 1'b1
    } lq_state_e;
endpackage

// File: rtl/lq_ring_ptr.sv
module lq_ring_ptr #(
    parameter int DEPTH = 5,
    parameter int W     = $clog2(DEPTH)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    input  logic         dec,
    output logic [W-1:0] ptr_o,
    output logic [W-1:0] ptr_inc_o,
    output logic [W-1:0] ptr_dec_o
);
    localparam logic [W-1:0] LAST = W'(DEPTH - 1);

    logic [W-1:0] ptr_q;

    always_comb begin
        ptr_inc_o = (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        ptr_dec_o = (ptr_q == '0) ? LAST : ptr_q - 1'b1;
        ptr_o     = ptr_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (inc && !dec)
            ptr_q <= ptr_inc_o;
        else if (dec && !inc)
            ptr_q <= ptr_dec_o;
    end

    // R2: the pointer stays inside the ring
    a_r2_ptr_range: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q <= LAST);
endmodule

// File: rtl/lq_free_calc.sv
module lq_free_calc #(
    parameter int LQ_CAP = 4,
    parameter int SQ_CAP = 4,
    parameter int LW     = 4,
    parameter int SW     = 3,
    parameter int OW     = 3
) (
    input  logic [LW-1:0] lq_occ_i,
    input  logic [SW-1:0] sq_cnt_i,
    output logic [OW-1:0] free_o
);
    int lq_room;
    int sq_room;

    always_comb begin
        lq_room = LQ_CAP - int'(lq_occ_i);
        sq_room = (int'(sq_cnt_i) >= SQ_CAP) ? 0 : SQ_CAP - int'(sq_cnt_i);
        free_o  = OW'((lq_room < sq_room) ? lq_room : sq_room);
    end
endmodule

// File: rtl/load_queue.sv
module load_queue
    import lq_pkg::*;
#(
    parameter int  CAP      = 4,
    parameter int  SQ_CAP   = 4,
    parameter int  SEQ_W    = 8,
    parameter int  ADDR_W   = 16,
    localparam int DEPTH    = CAP + 1,
    localparam int IDX_W    = $clog2(DEPTH),
    localparam int CNT_W    = $clog2(CAP + 1),
    localparam int SQ_IDX_W = $clog2(SQ_CAP + 1),
    localparam int SQ_CNT_W = $clog2(SQ_CAP + 1),
    localparam int TAG_W    = SQ_IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_i,
    input  logic [SEQ_W-1:0]    alloc_seq_i,
    output logic                alloc_rdy_o,
    input  logic [SQ_IDX_W-1:0] sq_tail_i,
    input  logic [SQ_CNT_W-1:0] sq_cnt_i,
    input  logic                addr_wr_i,
    input  logic [IDX_W-1:0]    addr_idx_i,
    input  logic [ADDR_W-1:0]   addr_val_i,
    input  logic                commit_i,
    input  logic [SEQ_W-1:0]    commit_seq_i,
    input  logic                squash_i,
    input  logic [SEQ_W-1:0]    squash_seq_i,
    input  logic                blk_set_i,
    input  logic [SEQ_W-1:0]    blk_seq_i,
    output logic                blocked_o,
    output logic [SEQ_W-1:0]    blocked_seq_o,
    output logic                busy_o,
    output logic                ovf_o,
    output logic [CNT_W-1:0]    free_o,
    output logic [CNT_W-1:0]    occ_o,
    output logic [IDX_W-1:0]    head_o,
    output logic [IDX_W-1:0]    tail_o,
    output logic [DEPTH-1:0]    vld_o,
    output logic [SEQ_W-1:0]    head_seq_o,
    output logic [ADDR_W-1:0]   head_addr_o,
    output logic                head_av_o,
    output logic [TAG_W-1:0]    head_tag_o
);
    localparam logic [TAG_W-1:0] TAG_NONE  = '1;
    localparam logic [IDX_W:0]   DEPTH_X   = (IDX_W + 1)'(DEPTH);
    localparam logic [IDX_W:0]   CAP_X     = (IDX_W + 1)'(CAP);

    lq_state_e state_q, state_d;

    logic [DEPTH-1:0]  vld_q;
    logic [SEQ_W-1:0]  seq_q  [DEPTH];
    logic [ADDR_W-1:0] addr_q [DEPTH];
    logic [DEPTH-1:0]  av_q;
    logic [TAG_W-1:0]  tag_q  [DEPTH];

    logic [SEQ_W-1:0] bound_q;
    logic             ovf_q;
    logic             blk_q;
    logic [SEQ_W-1:0] blk_seq_q;

    logic [IDX_W-1:0] head_q, head_inc, head_dec;
    logic [IDX_W-1:0] tail_q, tail_inc, tail_dec;
    logic [IDX_W:0]   occ_w;
    logic             empty_w, full_w;
    logic             alloc_take, alloc_drop_full, commit_take, walk_take;

    lq_ring_ptr #(.DEPTH(DEPTH), .W(IDX_W)) i_head_ptr (
        .clk(clk), .rst_n(rst_n), .inc(commit_take), .dec(1'b0),
        .ptr_o(head_q), .ptr_inc_o(head_inc), .ptr_dec_o(head_dec)
    );

    lq_ring_ptr #(.DEPTH(DEPTH), .W(IDX_W)) i_tail_ptr (
        .clk(clk), .rst_n(rst_n), .inc(alloc_take), .dec(walk_take),
        .ptr_o(tail_q), .ptr_inc_o(tail_inc), .ptr_dec_o(tail_dec)
    );

    lq_free_calc #(.LQ_CAP(CAP), .SQ_CAP(SQ_CAP), .LW(IDX_W + 1),
                   .SW(SQ_CNT_W), .OW(CNT_W)) i_free (
        .lq_occ_i(occ_w), .sq_cnt_i(sq_cnt_i), .free_o(free_o)
    );

    // occupancy and request qualification
    always_comb begin
        if (tail_q >= head_q)
            occ_w = {1'b0, tail_q} - {1'b0, head_q};
        else
            occ_w = {1'b0, tail_q} + DEPTH_X - {1'b0, head_q};
        empty_w         = (head_q == tail_q);
        full_w          = (tail_inc == head_q);
        alloc_take      = alloc_i && (state_q == LQ_IDLE) && !squash_i && !full_w;
        alloc_drop_full = alloc_i && (state_q == LQ_IDLE) && !squash_i && full_w;
        commit_take     = commit_i && !empty_w && (seq_q[head_q] <= commit_seq_i);
        walk_take       = (state_q == LQ_WALK)
                        && (occ_w > {{IDX_W{1'b0}}, commit_take})
                        && (seq_q[tail_dec] > bound_q);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LQ_IDLE;
        else        state_q <= state_d;
    end

    // next state: start, step, stop
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LQ_IDLE: if (squash_i) state_d = LQ_WALK;
            LQ_WALK: if (!squash_i && !walk_take) state_d = LQ_IDLE;
            default: state_d = LQ_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o        = (state_q == LQ_WALK);
        alloc_rdy_o   = (state_q == LQ_IDLE) && !full_w;
        ovf_o         = ovf_q;
        occ_o         = CNT_W'(occ_w);
        head_o        = head_q;
        tail_o        = tail_q;
        vld_o         = vld_q;
        head_seq_o    = seq_q[head_q];
        head_addr_o   = addr_q[head_q];
        head_av_o     = av_q[head_q];
        head_tag_o    = tag_q[head_q];
        blocked_o     = blk_q;
        blocked_seq_o = blk_seq_q;
    end

    // flush bound, overflow pulse, blocked record
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bound_q   <= '0;
            ovf_q     <= 1'b0;
            blk_q     <= 1'b0;
            blk_seq_q <= '0;
        end else begin
            ovf_q <= alloc_drop_full;
            if (squash_i)
                bound_q <= (state_q == LQ_WALK && bound_q < squash_seq_i)
                         ? bound_q : squash_seq_i;
            if (blk_set_i) begin
                blk_q     <= 1'b1;
                blk_seq_q <= blk_seq_i;
            end else if (squash_i && blk_q && squash_seq_i < blk_seq_q) begin
                blk_q     <= 1'b0;
                blk_seq_q <= '0;
            end
        end
    end

    // entry storage
    generate
        for (genvar g = 0; g < DEPTH; g++) begin : g_slot
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    vld_q[g]  <= 1'b0;
                    av_q[g]   <= 1'b0;
                    seq_q[g]  <= '0;
                    addr_q[g] <= '0;
                    tag_q[g]  <= '0;
                end else begin
                    if (alloc_take && tail_q == IDX_W'(g)) begin
                        vld_q[g] <= 1'b1;
                        av_q[g]  <= 1'b0;
                        seq_q[g] <= alloc_seq_i;
                        tag_q[g] <= (sq_cnt_i == '0) ? TAG_NONE
                                                      : TAG_W'(sq_tail_i);
                    end
                    if (addr_wr_i && addr_idx_i == IDX_W'(g) && vld_q[g]) begin
                        addr_q[g] <= addr_val_i;
                        av_q[g]   <= 1'b1;
                    end
                    if ((commit_take && head_q == IDX_W'(g)) ||
                        (walk_take && tail_dec == IDX_W'(g)))
                        vld_q[g] <= 1'b0;
                end
            end
        end
    endgenerate

    // R2: never more than CAP entries
    a_r2_cap_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ_w <= CAP_X);
    // R6: a dropped allocation leaves the tail alone and pulses the flag
    a_r6_full_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && !busy_o && !squash_i && occ_w == CAP_X)
        |=> ($stable(tail_q) && ovf_o));
    // R8: nothing is added while the walk runs
    a_r8_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (occ_w <= $past(occ_w)));
    // R4: the head only moves on a commit that covers it
    a_r4_commit_order: assert property (@(posedge clk) disable iff (!rst_n)
        (head_q != $past(head_q)) |->
        ($past(commit_i) && ($past(head_seq_o) <= $past(commit_seq_i))));
    // R12: valid bits match occupancy
    a_r12_vld_count: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(vld_q) == int'(occ_w));
    // R10: the blocked record only falls on an older flush
    a_r10_blk_clear: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(blk_q) |-> ($past(squash_i) && $past(squash_seq_i) < $past(blk_seq_q)));
endmodule

// File: tb/test_load_queue.sv
module test_load_queue;
    localparam int CLK_PERIOD = 10;
    localparam int CAP = 4;
    localparam int N_VEC = 12;
    // fields: op[29:28] (bit0 alloc, bit1 commit), aseq[27:20], cseq[19:12], occ[11:8], head seq[7:0]
    localparam logic [29:0] VEC [N_VEC] = '{
        {2'd1, 8'd10, 8'd0,   4'd1, 8'd10},
        {2'd1, 8'd20, 8'd0,   4'd2, 8'd10},
        {2'd2, 8'd0,  8'd5,   4'd2, 8'd10},
        {2'd2, 8'd0,  8'd10,  4'd1, 8'd20},
        {2'd1, 8'd30, 8'd0,   4'd2, 8'd20},
        {2'd3, 8'd40, 8'd25,  4'd2, 8'd30},
        {2'd1, 8'd50, 8'd0,   4'd3, 8'd30},
        {2'd1, 8'd60, 8'd0,   4'd4, 8'd30},
        {2'd2, 8'd0,  8'd255, 4'd3, 8'd40},
        {2'd2, 8'd0,  8'd255, 4'd2, 8'd50},
        {2'd2, 8'd0,  8'd255, 4'd1, 8'd60},
        {2'd2, 8'd0,  8'd255, 4'd0, 8'd0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic alloc_i = 0, addr_wr_i = 0, commit_i = 0, squash_i = 0, blk_set_i = 0;
    logic [7:0] alloc_seq_i = 0, commit_seq_i = 0, squash_seq_i = 0, blk_seq_i = 0;
    logic [2:0] sq_tail_i = 0, sq_cnt_i = 0, addr_idx_i = 0;
    logic [15:0] addr_val_i = 0;
    logic alloc_rdy_o, blocked_o, busy_o, ovf_o, head_av_o;
    logic [7:0] blocked_seq_o, head_seq_o;
    logic [2:0] free_o, occ_o, head_o, tail_o;
    logic [4:0] vld_o;
    logic [15:0] head_addr_o;
    logic [3:0] head_tag_o;
    int checks = 0, fails = 0;
    bit done = 0;

    load_queue i_load_queue (
        .clk(clk), .rst_n(rst_n), .alloc_i(alloc_i), .alloc_seq_i(alloc_seq_i),
        .alloc_rdy_o(alloc_rdy_o), .sq_tail_i(sq_tail_i), .sq_cnt_i(sq_cnt_i),
        .addr_wr_i(addr_wr_i), .addr_idx_i(addr_idx_i), .addr_val_i(addr_val_i),
        .commit_i(commit_i), .commit_seq_i(commit_seq_i), .squash_i(squash_i),
        .squash_seq_i(squash_seq_i), .blk_set_i(blk_set_i), .blk_seq_i(blk_seq_i),
        .blocked_o(blocked_o), .blocked_seq_o(blocked_seq_o), .busy_o(busy_o),
        .ovf_o(ovf_o), .free_o(free_o), .occ_o(occ_o), .head_o(head_o),
        .tail_o(tail_o), .vld_o(vld_o), .head_seq_o(head_seq_o),
        .head_addr_o(head_addr_o), .head_av_o(head_av_o), .head_tag_o(head_tag_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #1;
        alloc_i = 0; commit_i = 0; squash_i = 0; blk_set_i = 0; addr_wr_i = 0;
    endtask

    task automatic do_alloc(input int s);
        alloc_i = 1; alloc_seq_i = 8'(s); cyc();
    endtask

    task automatic do_commit(input int s);
        commit_i = 1; commit_seq_i = 8'(s); cyc();
    endtask

    task automatic wait_idle();
        for (int k = 0; k < 20 && busy_o; k++) cyc();
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        chk("R1 occ", occ_o, 0);
        chk("R1 vld", vld_o, 0);
        chk("R1 busy", busy_o, 0);
        chk("R1 ovf", ovf_o, 0);
        chk("R1 blocked", blocked_o, 0);
        chk("R1 free", free_o, 4);

        // R2 R4 R5 table: alloc, commit, both together, pointer wrap
        for (int k = 0; k < N_VEC; k++) begin
            alloc_i = VEC[k][28]; commit_i = VEC[k][29];
            alloc_seq_i = VEC[k][27:20]; commit_seq_i = VEC[k][19:12];
            cyc();
            chk($sformatf("R2/R4/R5 vec%0d occ", k), occ_o, int'(VEC[k][11:8]));
            if (VEC[k][11:8] != 0)
                chk($sformatf("R4/R5 vec%0d head", k), head_seq_o, int'(VEC[k][7:0]));
        end

        // R3 store tag, R9 free count, R11 address write
        sq_cnt_i = 0;
        do_alloc(1);
        chk("R3 none tag", head_tag_o, 15);
        chk("R11 new entry flag clear", head_av_o, 0);
        sq_cnt_i = 2; sq_tail_i = 3;
        do_alloc(2);
        do_commit(1);
        chk("R3 store tail tag", head_tag_o, 3);
        sq_cnt_i = 3;
        #1 chk("R9 free limited by store side", free_o, 1);
        sq_cnt_i = 0;
        #1 chk("R9 free limited by load side", free_o, 3);
        addr_wr_i = 1; addr_idx_i = head_o; addr_val_i = 16'hBEEF; cyc();
        chk("R11 addr", head_addr_o, 16'hBEEF);
        chk("R11 flag", head_av_o, 1);
        do_commit(255);

        // R6 overflow
        for (int k = 0; k < CAP; k++) do_alloc(k + 1);
        chk("R2 full occ", occ_o, 4);
        chk("R2 rdy low when full", alloc_rdy_o, 0);
        do_alloc(9);
        chk("R6 ovf pulse", ovf_o, 1);
        chk("R6 occ kept", occ_o, 4);
        cyc();
        chk("R6 ovf one cycle", ovf_o, 0);
        for (int k = 0; k < CAP; k++) do_commit(255);

        // R7 R8 flush walk with allocation while busy
        do_alloc(100); do_alloc(110); do_alloc(120); do_alloc(130);
        squash_i = 1; squash_seq_i = 110; cyc();
        chk("R7 busy after request", busy_o, 1);
        chk("R7 nothing removed yet", occ_o, 4);
        do_alloc(140);
        chk("R8 alloc dropped while busy", occ_o, 3);
        chk("R7 still busy", busy_o, 1);
        cyc();
        chk("R7 second step", occ_o, 2);
        chk("R7 busy for N+1", busy_o, 1);
        cyc();
        chk("R7 stop", busy_o, 0);
        chk("R7 occ after walk", occ_o, 2);
        do_alloc(115);
        chk("R7 order head", head_seq_o, 100);
        do_commit(255);
        chk("R7 order second", head_seq_o, 110);
        do_commit(255);
        chk("R7 order third", head_seq_o, 115);
        do_commit(255);

        // R8 allocation in the same cycle as a flush request
        alloc_i = 1; alloc_seq_i = 7; squash_i = 1; squash_seq_i = 200; cyc();
        chk("R8 same-cycle alloc dropped", occ_o, 0);
        chk("R8 no ovf", ovf_o, 0);
        cyc();
        chk("R7 empty walk stops", busy_o, 0);

        // R10 blocked record
        blk_set_i = 1; blk_seq_i = 50; cyc();
        chk("R10 set", blocked_o, 1);
        chk("R10 seq", blocked_seq_o, 50);
        squash_i = 1; squash_seq_i = 60; cyc();
        chk("R10 younger flush keeps", blocked_o, 1);
        wait_idle();
        squash_i = 1; squash_seq_i = 40; cyc();
        chk("R10 older flush clears", blocked_o, 0);
        chk("R10 seq cleared", blocked_seq_o, 0);
        wait_idle();

        // R12 commit and flush in the same cycle
        do_alloc(100); do_alloc(110); do_alloc(120);
        commit_i = 1; commit_seq_i = 100; squash_i = 1; squash_seq_i = 105; cyc();
        chk("R12 commit with flush", occ_o, 2);
        chk("R12 head after commit", head_seq_o, 110);
        wait_idle();
        chk("R12 occ after walk", occ_o, 0);
        chk("R12 vld clear", vld_o, 0);
        chk("R12 head equals tail", int'(head_o == tail_o), 1);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule